// File: doc/BRIEF.md
# Signed-Digit Conversion Result Assembler

This block is the digital back end of a two-stage cyclic analog-to-digital converter. The two analog stages take turns, and each turn produces one three-valued decision digit. The block receives the digit of whichever stage is active, one digit per clock, where one clock stands for one half-cycle of the converter clock. It weights each digit by its position and adds them into a signed sum. It then shifts the sum to mid-scale and clamps it, which gives an unsigned 12-bit code. Because each digit can take three values, an analog decision that falls slightly off its ideal threshold is absorbed in the later digits. No separate correction step is needed.

A conversion starts when `sync_in` is seen high while the block is idle. The next clock is the input-sampling slot, and the twelve clocks after it each take one digit. The block drives `stage_sel` to tell the analog side which stage must deliver the next digit. When the last digit has been summed, the result appears on `code_out` together with a one-clock `code_valid` strobe. The result stays on `code_out` until the next conversion completes.

Top module: `rsd_code_assembler`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `code_out` is 0 and `code_valid` and `stage_sel` are low.
- R2: The clock edge that sees `sync_in` high while the block is idle begins a one-clock sampling slot. The next 12 rising edges each capture `digit_in` as digits 0 to 11, in that order.
- R3: Digit code 2'b10 counts as +1, 2'b01 counts as 0 and 2'b00 counts as -1. The unused code 2'b11 counts as 0.
- R4: The result is 2048 plus the sum of d_i·2^(11-i) for i = 0 to 11, so digit 0 carries the largest weight.
- R5: The result is clamped to the range 0 to 4095. All +1 digits give 4095 and all -1 digits give 0.
- R6: `code_valid` is high for exactly one clock. That clock follows the edge that captures digit 11, and `code_out` shows the new result from that clock onward. `code_out` changes at no other time.
- R7: A `sync_in` pulse during the sampling slot or during digit capture has no effect on the running conversion.
- R8: `stage_sel` is 0 while even-numbered digits (0, 2, …) are expected and 1 while odd-numbered digits are expected. It is 0 outside digit capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle phase clock, one digit slot per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Conversion start request, acted on only when idle |
| digit_in | input | 2 | Decision digit from the active stage |
| code_out | output | 12 | Clamped unsigned conversion result |
| code_valid | output | 1 | One-clock strobe marking a new result |
| stage_sel | output | 1 | Which stage must supply the next digit (0 first, 1 second) |

## Verification
The bound checker watches the following on every clock:
- the sequencing: the sampling slot is always followed by digit 0, and no new start is taken while a conversion runs;
- the single-clock result strobe, and the fact that it comes only after the last digit slot;
- `code_out` staying unchanged between strobes;
- the alternation of `stage_sel` and its low value outside capture.

The numeric side can only be shown by the bench scenarios, because it depends on the digit values actually driven. That covers the signed digit weighting, the treatment of the unused code, and clamping at both ends of the range. The bench compares these against an integer reference on every clock, using saturating patterns, neutral patterns and many random digit sequences, some of which include stray sync pulses.

// File: rtl/rsd_pkg.sv
// Shared types and helpers for the signed-digit result assembler.
// Assumes digits arrive as 2-bit codes: 10 = +1, 01 = 0, 00 = -1, 11 = 0.
package rsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_CONV = 2'd2
    } rsd_state_e;

    // Decode a stage decision code into a signed two-bit value.
    function automatic logic signed [1:0] digit_value(input logic [1:0] code);
        case (code)
            2'b10:   digit_value = 2'sd1;
            2'b00:   digit_value = -2'sd1;
            default: digit_value = 2'sd0;
        endcase
    endfunction

endpackage

// File: rtl/rsd_seq_ctrl.sv
// Conversion sequencer: idle -> one sampling slot -> N_DIGITS digit slots.
// Assumes one digit slot per clock; a start request is honoured only in idle.
module rsd_seq_ctrl
    import rsd_pkg::*;
#(
    parameter int N_DIGITS = 12,
    localparam int CNT_W = $clog2(N_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output rsd_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             first_slot,
    output logic             last_slot,
    output logic             stage_sel
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_DIGITS - 1);

    // State and digit-slot counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (sync_in) state <= ST_SAMP;
                ST_SAMP: begin
                    state <= ST_CONV;
                    cnt   <= '0;
                end
                ST_CONV: begin
                    if (cnt == LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot markers and active-stage indication.
    always_comb begin
        first_slot = (state == ST_CONV) && (cnt == '0);
        last_slot  = (state == ST_CONV) && (cnt == LAST);
        stage_sel  = (state == ST_CONV) && cnt[0];
    end

endmodule

// File: rtl/rsd_accum.sv
// Signed shift-and-add accumulator: acc = 2*acc + digit per slot, so the
// first digit ends with weight 2^(N_DIGITS-1). Assumes en marks digit slots.
module rsd_accum
    import rsd_pkg::*;
#(
    parameter int N_DIGITS = 12,
    localparam int ACC_W = N_DIGITS + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first_slot,
    input  logic [1:0]              digit_in,
    output logic signed [ACC_W-1:0] acc_next
);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] dig_ext;
    logic signed [ACC_W-1:0] base;

    // Next partial sum: restart on the first slot, else double and add.
    always_comb begin
        logic signed [1:0] dv;
        dv       = digit_value(digit_in);
        dig_ext  = {{(ACC_W-2){dv[1]}}, dv};
        base     = first_slot ? '0 : {acc[ACC_W-2:0], 1'b0};
        acc_next = base + dig_ext;
    end

    // Partial-sum register.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= acc_next;
    end

endmodule

// File: rtl/rsd_result_stage.sv
// Adds the mid-scale bias, clamps to the unsigned code range and registers
// the result with a one-clock valid strobe. Assumes load pulses once per result.
module rsd_result_stage #(
    parameter int N_DIGITS = 12,
    localparam int ACC_W = N_DIGITS + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] sum_in,
    output logic [N_DIGITS-1:0]     code_out,
    output logic                    code_valid
);

    localparam logic [ACC_W:0] MID = (ACC_W+1)'(1) << (N_DIGITS - 1);

    logic [ACC_W:0]        biased;
    logic [N_DIGITS-1:0]   clamped;

    // Bias to mid-scale and clamp: negative -> 0, above range -> all ones.
    always_comb begin
        biased = {sum_in[ACC_W-1], sum_in} + MID;
        if (biased[ACC_W])
            clamped = '0;
        else if (|biased[ACC_W-1:N_DIGITS])
            clamped = '1;
        else
            clamped = biased[N_DIGITS-1:0];
    end

    // Result register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= load;
            if (load) code_out <= clamped;
        end
    end

endmodule

// File: rtl/rsd_code_assembler.sv
// Top level: turns alternating-stage signed digits into a clamped binary code.
// Assumes digit_in is stable around each rising edge of the half-cycle clock.
module rsd_code_assembler
    import rsd_pkg::*;
#(
    parameter int N_DIGITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic [1:0]          digit_in,
    output logic [N_DIGITS-1:0] code_out,
    output logic                code_valid,
    output logic                stage_sel
);

    localparam int CNT_W = $clog2(N_DIGITS);
    localparam int ACC_W = N_DIGITS + 2;

    rsd_state_e              state;
    logic [CNT_W-1:0]        cnt;
    logic                    first_slot;
    logic                    last_slot;
    logic signed [ACC_W-1:0] acc_next;

    rsd_seq_ctrl #(.N_DIGITS(N_DIGITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .state      (state),
        .cnt        (cnt),
        .first_slot (first_slot),
        .last_slot  (last_slot),
        .stage_sel  (stage_sel)
    );

    rsd_accum #(.N_DIGITS(N_DIGITS)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (state == ST_CONV),
        .first_slot (first_slot),
        .digit_in   (digit_in),
        .acc_next   (acc_next)
    );

    rsd_result_stage #(.N_DIGITS(N_DIGITS)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (last_slot),
        .sum_in     (acc_next),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

endmodule

// File: rtl/rsd_code_assembler_chk.sv
// Protocol checker for the assembler; observes ports and sequencer state.
module rsd_code_assembler_chk
    import rsd_pkg::*;
#(
    parameter int N_DIGITS = 12,
    localparam int CNT_W = $clog2(N_DIGITS)
) (
    input logic                clk,
    input logic                rst_n,
    input rsd_state_e          state,
    input logic [CNT_W-1:0]    cnt,
    input logic [N_DIGITS-1:0] code_out,
    input logic                code_valid,
    input logic                stage_sel
);

    // R2
    samp_to_first_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SAMP |=> (state == ST_CONV && cnt == '0));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |=> state != ST_SAMP);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    // R6
    valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> ($past(state) == ST_CONV && $past(cnt) == CNT_W'(N_DIGITS - 1)));

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(code_out));

    // R8
    stage_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_sel |=> !stage_sel);

    // R8
    stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_CONV |-> !stage_sel);

endmodule

bind rsd_code_assembler rsd_code_assembler_chk #(.N_DIGITS(N_DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cnt        (cnt),
    .code_out   (code_out),
    .code_valid (code_valid),
    .stage_sel  (stage_sel)
);

// File: tb/rsd_code_assembler_test.sv
module rsd_code_assembler_test;

    localparam int N    = 12;
    localparam int MAXV = (1 << N) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n    = 1'b0;
    logic         sync_in  = 1'b0;
    logic [1:0]   digit_in = 2'b01;
    wire  [N-1:0] code_out;
    wire          code_valid;
    wire          stage_sel;

    rsd_code_assembler #(.N_DIGITS(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .digit_in   (digit_in),
        .code_out   (code_out),
        .code_valid (code_valid),
        .stage_sel  (stage_sel)
    );

    int vectors = 0;
    int errs    = 0;

    // Behavioural reference: phase -1 idle, 0 sampling, k+1 waiting digit k.
    int mphase    = -1;
    int macc      = 0;
    int exp_code  = 0;
    bit exp_valid = 1'b0;
    bit exp_stage = 1'b0;

    // R3: digit decoding used by the reference.
    function automatic int dval(input logic [1:0] d);
        case (d)
            2'b10:   return 1;
            2'b00:   return -1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mphase = -1; macc = 0; exp_code = 0; exp_valid = 1'b0;
        end else begin
            exp_valid = 1'b0;
            if (mphase == -1) begin
                if (sync_in) mphase = 0;          // R2 start; R7 ignored otherwise
            end else if (mphase == 0) begin
                mphase = 1; macc = 0;
            end else begin
                macc = macc + dval(digit_in) * (1 << (N - mphase));   // R4
                if (mphase == N) begin
                    int v;
                    v = macc + (1 << (N - 1));
                    if (v < 0) v = 0;             // R5
                    if (v > MAXV) v = MAXV;       // R5
                    exp_code  = v;
                    exp_valid = 1'b1;
                    mphase    = -1;
                end else begin
                    mphase = mphase + 1;
                end
            end
        end
        exp_stage = (mphase >= 1) && (((mphase - 1) % 2) == 1);
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (code_valid !== exp_valid) begin
                errs++;
                $display("FAIL R6 code_valid got %0b exp %0b at %0t", code_valid, exp_valid, $time);
            end
            if (code_out !== N'(exp_code)) begin
                errs++;
                $display("FAIL R4 code_out (timing R2, decode R3, clamp R5, sync R7) got %0d exp %0d at %0t",
                         code_out, exp_code, $time);
            end
            if (stage_sel !== exp_stage) begin
                errs++;
                $display("FAIL R8 stage_sel got %0b exp %0b at %0t", stage_sel, exp_stage, $time);
            end
        end
    end

    task automatic run_conv(input logic [1:0] d [N], input bit stray_sync);
        @(negedge clk) sync_in = 1'b1;
        @(negedge clk) begin sync_in = stray_sync; digit_in = 2'($urandom); end
        for (int i = 0; i < N; i++) begin
            @(negedge clk) begin
                digit_in = d[i];
                sync_in  = stray_sync && (i == 5 || i == N - 1);   // R7
            end
        end
        @(negedge clk) begin sync_in = 1'b0; digit_in = 2'b01; end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_fill(input logic [1:0] code);
        logic [1:0] d [N];
        for (int i = 0; i < N; i++) d[i] = code;
        run_conv(d, 1'b0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] d [N];
        // R1: outputs during reset.
        repeat (3) begin
            @(negedge clk);
            vectors++;
            if (code_out !== '0 || code_valid !== 1'b0 || stage_sel !== 1'b0) begin
                errs++;
                $display("FAIL R1 reset outputs got %0d/%0b/%0b exp 0/0/0", code_out, code_valid, stage_sel);
            end
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_fill(2'b10);      // R5 upper clamp -> 4095
        run_fill(2'b00);      // R5 lower clamp -> 0
        run_fill(2'b01);      // R3 zero digits -> 2048
        run_fill(2'b11);      // R3 unused code -> 2048

        // R4: first digit +1, rest -1 -> 2049
        d[0] = 2'b10;
        for (int i = 1; i < N; i++) d[i] = 2'b00;
        run_conv(d, 1'b0);

        // R4: last digit +1 only -> 2049
        for (int i = 0; i < N; i++) d[i] = 2'b01;
        d[N-1] = 2'b10;
        run_conv(d, 1'b0);

        // R4, R7: random digit streams, some with stray sync pulses.
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < N; i++) d[i] = 2'($urandom);
            run_conv(d, bit'(k % 3 == 0));
        end

        summary();
        $finish;
    end

endmodule